// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A start address is captured with a load strobe; each following advance strobe moves to the next beat. Only the two least significant address bits move during a burst; all higher bits are copied from the loaded address and stay fixed. After the fourth beat the sequence returns to the start address and keeps cycling.

A static strap input selects one of two beat orders. In interleaved order, each beat's low bits are the start bits XOR a beat count. In linear order, each beat's low bits are the start bits plus the beat count, modulo four. A hold input freezes the sequencer for as many cycles as it is high, so a burst can be suspended and later resumed. The output address comes straight from a register.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cur_addr` becomes all zeros at that edge and the beat count is cleared.
- R2: With `hold` low and `load` high at an edge, `cur_addr` equals `ext_addr` after that edge, and the beat count restarts at zero.
- R3: With `mode_ilv` = 1 (interleaved), beat k of a burst (k = 0..3) has low two bits equal to start[1:0] XOR k.
- R4: With `mode_ilv` = 0 (linear), beat k of a burst has low two bits equal to (start[1:0] + k) mod 4.
- R5: An advance never changes bits above bit 1. There is no carry out of the low two bits, even when the upper bits are all ones.
- R6: Advances past the fourth beat continue the same four-address cycle without stopping. Beat k+4 equals beat k.
- R7: With `hold` high at an edge, `cur_addr` and the burst position do not change, whatever `load`, `adv` and `ext_addr` carry. The next advance after `hold` drops gives the beat that follows the held one.
- R8: When `load` and `adv` are both high with `hold` low, the load takes effect and the advance is ignored.
- R9: With `hold`, `load` and `adv` all low, `cur_addr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Suspends the sequencer while high |
| load | input | 1 | Captures `ext_addr` as a new burst start |
| adv | input | 1 | Steps to the next beat |
| mode_ilv | input | 1 | Static order strap: 1 = interleaved, 0 = linear |
| ext_addr | input | ADDR_W | External start address |
| cur_addr | output | ADDR_W | Registered current beat address |

## Verification
The interesting overlaps are a load arriving in the same cycle as an advance, and a hold arriving in the same cycle as a load or advance. Each is provoked in the middle of a running burst, with `ext_addr` set to a value that differs from the current address. The collision is then judged on the next beat. After load plus advance, the output must show the new start address, and the advance that follows must give beat 1 of the new burst. After hold plus load or advance, the output must be unchanged, and the first advance once hold drops must give the beat after the one that was held.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Per-cycle action of the sequencer, decoded from the strobes
  typedef enum logic [1:0] {
    OP_KEEP    = 2'd0,
    OP_SUSPEND = 2'd1,
    OP_LOAD    = 2'd2,
    OP_STEP    = 2'd3
  } burst_op_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic      hold,
  input  logic      load,
  input  logic      adv,
  output burst_op_e op
);

  // Priority: suspend over load over step
  always_comb begin
    if (hold)      op = OP_SUSPEND;
    else if (load) op = OP_LOAD;
    else if (adv)  op = OP_STEP;
    else           op = OP_KEEP;
  end

endmodule

// File: rtl/burst_counter.sv
module burst_counter
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  burst_op_e         op,
  output logic [BEAT_W-1:0] cnt_nxt
);

  logic [BEAT_W-1:0] cnt_q;

  always_comb begin
    case (op)
      OP_LOAD: cnt_nxt = '0;
      OP_STEP: cnt_nxt = cnt_q + 1'b1;   // natural wrap gives the cycle
      default: cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/burst_order.sv
module burst_order #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  logic              ilv,
  output logic [BEAT_W-1:0] offs_lo
);

  logic [BEAT_W-1:0] xor_lo;
  logic [BEAT_W-1:0] sum_lo;

  // Interleaved: bitwise, no carry chain
  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_lo[b] = start_lo[b] ^ beat[b];
  end

  // Linear: modular add inside the low field only
  assign sum_lo  = start_lo + beat;
  assign offs_lo = ilv ? xor_lo : sum_lo;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              load,
  input  logic              adv,
  input  logic              mode_ilv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int UP_W = ADDR_W - BEAT_W;

  burst_op_e         op;
  logic [BEAT_W-1:0] cnt_nxt;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_lo;
  logic [ADDR_W-1:0] addr_q;

  burst_ctrl i_ctrl (
    .hold (hold),
    .load (load),
    .adv  (adv),
    .op   (op)
  );

  burst_counter #(.BEAT_W(BEAT_W)) i_cnt (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .cnt_nxt (cnt_nxt)
  );

  burst_order #(.BEAT_W(BEAT_W)) i_order (
    .start_lo (start_q),
    .beat     (cnt_nxt),
    .ilv      (mode_ilv),
    .offs_lo  (beat_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      addr_q  <= '0;
    end else begin
      case (op)
        OP_LOAD: begin
          start_q <= ext_addr[BEAT_W-1:0];
          addr_q  <= ext_addr;
        end
        OP_STEP: begin
          addr_q <= {addr_q[ADDR_W-1 -: UP_W], beat_lo};
        end
        default: ;
      endcase
    end
  end

  assign cur_addr = addr_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              hold,
  input logic              load,
  input logic              adv,
  input logic              mode_ilv,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] cur_addr
);

  logic [BEAT_W-1:0] lo_inc;
  always_comb lo_inc = cur_addr[BEAT_W-1:0] + 1'b1;

  // R1
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (cur_addr == '0));

  // R2
  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!hold && load) |=> (cur_addr == $past(ext_addr)));

  // R3
  p_ilv_lsb_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (!hold && !load && adv && mode_ilv) |=>
      (cur_addr[0] != $past(cur_addr[0])));

  // R4
  p_lin_increment_r4: assert property (@(posedge clk) disable iff (rst)
    (!hold && !load && adv && !mode_ilv) |=>
      (cur_addr[BEAT_W-1:0] == $past(lo_inc)));

  // R5
  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));

  // R7
  p_suspend_r7: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(cur_addr));

  // R9
  p_idle_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (!hold && !load && !adv) |=> $stable(cur_addr));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .hold     (hold),
  .load     (load),
  .adv      (adv),
  .mode_ilv (mode_ilv),
  .ext_addr (ext_addr),
  .cur_addr (cur_addr)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hold = 1'b0;
  logic          load = 1'b0;
  logic          adv = 1'b0;
  logic          mode_ilv = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) i_burst_addr_gen (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .load     (load),
    .adv      (adv),
    .mode_ilv (mode_ilv),
    .ext_addr (ext_addr),
    .cur_addr (cur_addr)
  );

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s,
                                              input int k, input logic ilv);
    logic [1:0] kk;
    logic [1:0] lo;
    kk = 2'(k % 4);
    lo = ilv ? (s[1:0] ^ kk) : (s[1:0] + kk);
    return {s[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] got,
                     input logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: cur_addr=%h expected=%h", tag, got, exp);
    end
  endtask

  // Apply strobes for one edge, then wait until well after it
  task automatic cyc(input logic l, input logic a, input logic h,
                     input logic [AW-1:0] e);
    load = l; adv = a; hold = h; ext_addr = e;
    @(posedge clk);
    #2;
    load = 1'b0; adv = 1'b0; hold = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, 20'hFFFFF);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R1 reset", cur_addr, '0);
    rst = 1'b0;
  endtask

  task automatic t_burst(input logic ilv, input logic [AW-1:0] s);
    string tag;
    tag = ilv ? "R3 interleaved" : "R4 linear";
    mode_ilv = ilv;
    cyc(1'b1, 1'b0, 1'b0, s);
    chk("R2 load", cur_addr, s);
    for (int k = 1; k < 4; k++) begin
      cyc(1'b0, 1'b1, 1'b0, ~s);
      chk(tag, cur_addr, beat_addr(s, k, ilv));
    end
  endtask

  task automatic t_wrap(input logic ilv);
    logic [AW-1:0] s;
    s = 20'hFFFFF;
    mode_ilv = ilv;
    cyc(1'b1, 1'b0, 1'b0, s);
    for (int k = 1; k <= 9; k++) begin
      cyc(1'b0, 1'b1, 1'b0, '0);
      chk("R6 wrap", cur_addr, beat_addr(s, k, ilv));
      chk("R5 no carry", {cur_addr[AW-1:2], 2'b00}, {s[AW-1:2], 2'b00});
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] s;
    s = 20'h12346;
    mode_ilv = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, s);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R7 pre-hold", cur_addr, beat_addr(s, 1, 1'b1));
    cyc(1'b0, 1'b1, 1'b1, 20'h0AAAA);
    chk("R7 hold+adv", cur_addr, beat_addr(s, 1, 1'b1));
    cyc(1'b1, 1'b0, 1'b1, 20'h0AAAA);
    chk("R7 hold+load", cur_addr, beat_addr(s, 1, 1'b1));
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R7 resume", cur_addr, beat_addr(s, 2, 1'b1));
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R7 resume+1", cur_addr, beat_addr(s, 3, 1'b1));
  endtask

  task automatic t_collide();
    logic [AW-1:0] s;
    logic [AW-1:0] n;
    s = 20'h00F01;
    n = 20'h5A5A3;
    mode_ilv = 1'b0;
    cyc(1'b1, 1'b0, 1'b0, s);
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b1, 1'b1, 1'b0, n);
    chk("R8 load wins", cur_addr, n);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R8 new beat1", cur_addr, beat_addr(n, 1, 1'b0));
  endtask

  task automatic t_idle();
    logic [AW-1:0] s;
    s = 20'h31002;
    mode_ilv = 1'b0;
    cyc(1'b1, 1'b0, 1'b0, s);
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, 1'b0, 1'b0, 20'hFFFFF);
    chk("R9 idle", cur_addr, beat_addr(s, 1, 1'b0));
    cyc(1'b0, 1'b0, 1'b0, 20'h00000);
    chk("R9 idle2", cur_addr, beat_addr(s, 1, 1'b0));
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R9 then step", cur_addr, beat_addr(s, 2, 1'b0));
  endtask

  initial begin
    #1;
    t_reset();
    for (int m = 0; m < 2; m++) begin
      for (int st = 0; st < 4; st++) begin
        t_burst(m[0], {18'h2C0D5, 2'(st)});
      end
    end
    t_wrap(1'b0);
    t_wrap(1'b1);
    t_hold();
    t_collide();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule